// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Unit

This block gathers external interrupt requests for one processor and decides, at each instruction boundary, which exception (if any) the core must take. Three request sources feed it: a reset event, a non-maskable interrupt event, and a maskable level event that carries a 6-bit pattern of active hardware interrupt lines. Each source has its own pending state, which persists until the request is serviced or replaced.

At a boundary the unit services exactly one source, in strict order: reset first, then the non-maskable interrupt, then the maskable level. Reset and the non-maskable interrupt share one exception strobe. For a maskable request the unit copies the pattern into the hardware-interrupt field of the cause register. It raises the interrupt strobe only when the status global enable is set and the pattern overlaps the status mask. A masked request stays pending and is checked again at every later boundary. A level event whose value is zero marks the request as withdrawn. The next evaluation then clears the cause field and raises nothing.

Top module: `irq_delivery_unit`

## Requirements
- R1: While rst_ni is low and afterwards until the first event, cause_ip_o, exc_nmi_rst_o and exc_int_o are all 0, and a boundary with nothing pending raises no strobe.
- R2: All outputs are registered. A strobe on exc_nmi_rst_o or exc_int_o appears only in the cycle after a cycle with instr_boundary_i high, and it lasts one cycle.
- R3: At a boundary the unit services only one source. The order is: pending reset, then pending NMI, then level. A serviced reset or NMI pulses exc_nmi_rst_o and clears only its own flag. A lower source that was not serviced keeps cause_ip_o unchanged and stays pending.
- R4: If a nonzero level is pending and its evaluation is not preempted, cause_ip_o takes the pending pattern after the boundary. Bit k of the pattern is hardware interrupt line k.
- R5: The level evaluation pulses exc_int_o only when sr_ie_i is 1 and (pattern & sr_im_i) is nonzero. Acceptance clears the pending level.
- R6: A level that is disabled or masked stays pending and is evaluated again at each following boundary, until it is accepted or replaced.
- R7: A level event with lvl_val_i equal to 0 marks the level as withdrawn. The next evaluation sets cause_ip_o to 0, raises no strobe, and leaves no level pending.
- R8: A newer level event overwrites any older pending pattern.
- R9: If an event arrives in the same cycle as a boundary, the boundary evaluates the older state. The new event is latched and stays pending even when that boundary services the same source.

Top module port list order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rst_evt_i | input | 1 | Reset request event (one-cycle pulse) |
| nmi_evt_i | input | 1 | Non-maskable interrupt event |
| lvl_evt_i | input | 1 | Maskable level event |
| lvl_val_i | input | 6 | Level pattern; 0 means withdrawn |
| instr_boundary_i | input | 1 | Instruction boundary, evaluation allowed |
| sr_ie_i | input | 1 | Status global interrupt enable |
| sr_im_i | input | 6 | Status interrupt mask field |
| cause_ip_o | output | 6 | Cause hardware-interrupt field |
| exc_nmi_rst_o | output | 1 | Combined reset/NMI exception strobe |
| exc_int_o | output | 1 | Maskable interrupt exception strobe |

## Verification
The bench builds the unit with the default IP_W of 6. At that width every level pattern (1 to 63) can be swept against every mask value (0 to 63) and both enable settings. That sweep covers the full acceptance decision and the cause field loading, and each case ends with a withdrawal. Directed sequences cover the remaining behaviour: all three sources pending at once, masked requests that are retried and later accepted, overwrites of a pending pattern, and events that arrive in the cycle of a boundary.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    LVL_IDLE = 2'd0,
    LVL_ACT  = 2'd1,
    LVL_WD   = 2'd2
  } lvl_state_e;
endpackage

// File: rtl/irq_pend_flag.sv
module irq_pend_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // new event wins over service
    else if (clr_i) q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R9
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o); // R3
endmodule

// File: rtl/irq_level_slot.sv
module irq_level_slot
  import irq_pkg::*;
#(
  parameter int IP_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            evt_i,
  input  logic [IP_W-1:0] val_i,
  input  logic            done_i,   // accepted or withdrawal consumed
  output lvl_state_e      state_o,
  output logic [IP_W-1:0] pat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= LVL_IDLE;
      pat_o   <= '0;
    end else if (evt_i) begin
      state_o <= (val_i == '0) ? LVL_WD : LVL_ACT;
      pat_o   <= val_i;
    end else if (done_i) begin
      state_o <= LVL_IDLE;
    end
  end

  AST_DONE_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !evt_i) |=> state_o == LVL_IDLE); // R5
  AST_NEW_OVERWRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && val_i != '0) |=> (state_o == LVL_ACT && pat_o == $past(val_i))); // R8
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int IP_W = 6
) (
  input  logic            bnd_i,
  input  logic            rst_pend_i,
  input  logic            nmi_pend_i,
  input  lvl_state_e      lvl_state_i,
  input  logic [IP_W-1:0] lvl_pat_i,
  input  logic            ie_i,
  input  logic [IP_W-1:0] im_i,
  output logic            take_rst_o,
  output logic            take_nmi_o,
  output logic            lvl_wd_o,
  output logic            lvl_act_o,
  output logic            lvl_acc_o
);
  logic lvl_turn;

  always_comb begin
    take_rst_o = bnd_i && rst_pend_i;
    take_nmi_o = bnd_i && !rst_pend_i && nmi_pend_i;
    lvl_turn   = bnd_i && !rst_pend_i && !nmi_pend_i;
    lvl_wd_o   = lvl_turn && (lvl_state_i == LVL_WD);
    lvl_act_o  = lvl_turn && (lvl_state_i == LVL_ACT);
    lvl_acc_o  = lvl_act_o && ie_i && (|(lvl_pat_i & im_i));
  end
endmodule

// File: rtl/irq_delivery_unit.sv
module irq_delivery_unit
  import irq_pkg::*;
#(
  parameter int IP_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rst_evt_i,
  input  logic            nmi_evt_i,
  input  logic            lvl_evt_i,
  input  logic [IP_W-1:0] lvl_val_i,
  input  logic            instr_boundary_i,
  input  logic            sr_ie_i,
  input  logic [IP_W-1:0] sr_im_i,
  output logic [IP_W-1:0] cause_ip_o,
  output logic            exc_nmi_rst_o,
  output logic            exc_int_o
);
  logic            rst_pend, nmi_pend;
  lvl_state_e      lvl_state;
  logic [IP_W-1:0] lvl_pat;
  logic            take_rst, take_nmi, lvl_wd, lvl_act, lvl_acc;

  irq_pend_flag u_rst_flag (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (rst_evt_i), .clr_i (take_rst), .q_o (rst_pend)
  );

  irq_pend_flag u_nmi_flag (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (nmi_evt_i), .clr_i (take_nmi), .q_o (nmi_pend)
  );

  irq_level_slot #(.IP_W(IP_W)) u_lvl (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .evt_i (lvl_evt_i), .val_i (lvl_val_i),
    .done_i (lvl_acc || lvl_wd),
    .state_o (lvl_state), .pat_o (lvl_pat)
  );

  irq_arbiter #(.IP_W(IP_W)) u_arb (
    .bnd_i (instr_boundary_i),
    .rst_pend_i (rst_pend), .nmi_pend_i (nmi_pend),
    .lvl_state_i (lvl_state), .lvl_pat_i (lvl_pat),
    .ie_i (sr_ie_i), .im_i (sr_im_i),
    .take_rst_o (take_rst), .take_nmi_o (take_nmi),
    .lvl_wd_o (lvl_wd), .lvl_act_o (lvl_act), .lvl_acc_o (lvl_acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_ip_o    <= '0;
      exc_nmi_rst_o <= 1'b0;
      exc_int_o     <= 1'b0;
    end else begin
      exc_nmi_rst_o <= take_rst || take_nmi;
      exc_int_o     <= lvl_acc;
      if (lvl_wd)       cause_ip_o <= '0;
      else if (lvl_act) cause_ip_o <= lvl_pat;
    end
  end

  AST_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_nmi_rst_o && exc_int_o)); // R3
  AST_NMI_NEEDS_BND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_nmi_rst_o |-> $past(instr_boundary_i)); // R2
  AST_INT_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_int_o |-> ($past(instr_boundary_i) && $past(sr_ie_i))); // R5
  AST_CAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_boundary_i |=> $stable(cause_ip_o)); // R2
  AST_INT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_int_o && !instr_boundary_i) |=> !exc_int_o); // R2
endmodule

// File: tb/irq_delivery_unit_test.sv
module irq_delivery_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int IP_W = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rst_evt_i = 0, nmi_evt_i = 0, lvl_evt_i = 0, instr_boundary_i = 0, sr_ie_i = 0;
  logic [IP_W-1:0] lvl_val_i = '0, sr_im_i = '0;
  logic [IP_W-1:0] cause_ip_o;
  logic exc_nmi_rst_o, exc_int_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_delivery_unit #(.IP_W(IP_W)) uut (
    .clk_i (clk), .rst_ni (rst_ni),
    .rst_evt_i (rst_evt_i), .nmi_evt_i (nmi_evt_i),
    .lvl_evt_i (lvl_evt_i), .lvl_val_i (lvl_val_i),
    .instr_boundary_i (instr_boundary_i),
    .sr_ie_i (sr_ie_i), .sr_im_i (sr_im_i),
    .cause_ip_o (cause_ip_o), .exc_nmi_rst_o (exc_nmi_rst_o), .exc_int_o (exc_int_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input int cause, input int nr, input int it);
    chk(req, int'(cause_ip_o), cause);
    chk(req, int'(exc_nmi_rst_o), nr);
    chk(req, int'(exc_int_o), it);
  endtask

  // one clock: inputs already set; clears pulses after the edge
  task automatic tick(input bit bnd);
    instr_boundary_i = bnd;
    @(posedge clk); #1;
    instr_boundary_i = 0; rst_evt_i = 0; nmi_evt_i = 0; lvl_evt_i = 0;
  endtask

  task automatic lvl(input int v);
    lvl_evt_i = 1; lvl_val_i = v[IP_W-1:0];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    outs("R1 in reset", 0, 0, 0);
    rst_ni = 1;
    tick(1); outs("R1 idle boundary", 0, 0, 0);

    // R2: reset event waits for a boundary
    rst_evt_i = 1; tick(0);
    tick(0); outs("R2 no boundary", 0, 0, 0);
    tick(1); outs("R2 strobe", 0, 1, 0);
    tick(0); outs("R2 one cycle", 0, 0, 0);
    tick(1); outs("R3 reset cleared", 0, 0, 0);

    // R3: all three pending together
    sr_ie_i = 1; sr_im_i = 6'h3f;
    rst_evt_i = 1; nmi_evt_i = 1; lvl(6'h21); tick(0);
    tick(1); outs("R3 reset first", 0, 1, 0);
    tick(1); outs("R3 nmi second", 0, 1, 0);
    tick(1); outs("R3 level third", 6'h21, 0, 1);
    tick(1); outs("R5 level cleared", 6'h21, 0, 0);

    // R6: masked level retried
    sr_ie_i = 0; sr_im_i = 6'h04;
    lvl(6'h05); tick(0);
    tick(1); outs("R6 disabled", 6'h05, 0, 0);
    tick(1); outs("R6 still pending", 6'h05, 0, 0);
    sr_ie_i = 1; sr_im_i = 6'h02;
    tick(1); outs("R6 masked", 6'h05, 0, 0);
    sr_im_i = 6'h04;
    tick(1); outs("R6 accepted", 6'h05, 0, 1);
    tick(1); outs("R6 not again", 6'h05, 0, 0);

    // R8: overwrite
    sr_im_i = 6'h30;
    lvl(6'h03); tick(0);
    lvl(6'h30); tick(0);
    tick(1); outs("R8 newer pattern", 6'h30, 0, 1);

    // R9: event in boundary cycle
    sr_im_i = 6'h01;
    lvl(6'h01); tick(0);
    lvl(6'h02); tick(1); outs("R9 old evaluated", 6'h01, 0, 1);
    sr_im_i = 6'h02;
    tick(1); outs("R9 new pending", 6'h02, 0, 1);
    nmi_evt_i = 1; tick(0);
    nmi_evt_i = 1; tick(1); outs("R9 nmi serviced", 6'h02, 1, 0);
    tick(1); outs("R9 nmi re-pending", 6'h02, 1, 0);
    tick(1); outs("R9 nmi done", 6'h02, 0, 0);

    // R7: withdrawal
    sr_im_i = 6'h3f;
    lvl(6'h11); tick(0);
    lvl(0); tick(0);
    tick(1); outs("R7 withdrawn clears", 0, 0, 0);
    tick(1); outs("R7 nothing pending", 0, 0, 0);

    // R4 R5 R7 sweep
    for (int p = 1; p < 64; p++) begin
      for (int m = 0; m < 64; m++) begin
        for (int e = 0; e < 2; e++) begin
          int acc;
          acc = (e == 1 && (p & m) != 0) ? 1 : 0;
          sr_ie_i = e[0]; sr_im_i = m[IP_W-1:0];
          lvl(p); tick(0);
          tick(1); outs("R4 R5 sweep", p, 0, acc);
          lvl(0); tick(0);
          tick(1); outs("R7 sweep", 0, 0, 0);
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule